// File: doc/BRIEF.md
# Logarithmic 12-bit PWM Generator

This block turns an 8-bit brightness code into a 12-bit duty value and drives a fixed-frequency pulse-width output from it. A colour bank's current sources are switched by this output. Three copies are used, one for each colour bank. Most codes are mapped through a constant-decibel curve, so that brightness steps look even to the eye. A 2x scale setting doubles the decibel size of each code step. This trades fine resolution near full brightness for a wider dimming range. A plain linear mode is also available.

The period is 4096 ticks of a prescaled tick input. The prescaler sits outside the block and sets the output frequency, which is about 280 Hz in a typical system. A free-running 12-bit counter advances on each tick. The output is high while the counter is below the active duty. A changed code or mode takes effect only at the start of a period, so no period is ever cut short or stretched. When the enable is low, the output is low and the counter is cleared. While disabled, the active duty follows the code, so the first period after enabling already uses the current setting.

Top module: `logpwm_gen`

## Requirements
- R1: While reset is asserted, and until the first enabled clock edge after it, `pwm_o` is low.
- R2: When enabled, the 12-bit period counter advances by exactly one on each clock with `tick_i` high. It holds when `tick_i` is low and wraps from 4095 to 0, so one period is 4096 ticks.
- R3: While enabled, `pwm_o` is high exactly while the counter is below the active duty. A duty of 4095 therefore gives 4095 high ticks out of 4096.
- R4: In log mode with 1x scale (`lin_mode_i`=0, `x2_scale_i`=0), code c from 1 to 255 gives a duty within ±1 of round(4095·10^((c−255)·0.17/20)). Each code step is 0.17 dB.
- R5: In log mode with 2x scale (`lin_mode_i`=0, `x2_scale_i`=1), code c from 1 to 255 gives a duty within ±1 of round(4095·10^((c−255)·0.34/20)).
- R6: Code 0 gives a duty of 0 in both log scales, so the output stays low for the whole period.
- R7: In linear mode (`lin_mode_i`=1), the duty is 16·c, which is 1/256 of full scale per code step. `x2_scale_i` has no effect in this mode.
- R8: The mode bits are decoded as follows. `lin_mode_i`=1 selects linear. Otherwise `x2_scale_i`=0 selects 1x log and `x2_scale_i`=1 selects 2x log. The same code gives the duty of the selected curve.
- R9: While enabled, a new duty from a changed code or mode is taken only at the clock edge where a tick arrives with the counter at 4095. While disabled, the active duty follows the code and mode at every clock.
- R10: With `en_i` low at a clock edge, `pwm_o` is low after that edge and the counter restarts from 0 when enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Enable; low holds the output low and clears the counter |
| tick_i | input | 1 | Prescaled tick; one counter step per clock it is high |
| code_i | input | 8 | Brightness code |
| lin_mode_i | input | 1 | 1 selects the linear curve |
| x2_scale_i | input | 1 | In log mode, 1 selects the 0.34 dB step |
| pwm_o | output | 1 | Pulse-width output to the bank's current sources |

## Verification
The bench uses the default widths: an 8-bit code and a 12-bit duty. With these, the period is 4096 ticks, so a full period of high ticks can be counted in a few thousand cycles, and every curve point can be measured exactly. The bench drives the tick on every clock for most tests and on every third clock for one test. This brings both the advance and the hold of the counter into reach. A cycle-by-cycle model of the counter and the active duty covers the mid-period code change and the wrap where it must take effect.

// File: rtl/logpwm_pkg.sv
package logpwm_pkg;

  parameter int CODE_W_DEF = 8;
  parameter int DUTY_W_DEF = 12;

  // Attenuation per code step: 10^(-0.17/20) in unsigned Q0.24.
  parameter int unsigned RATIO_FRAC = 24;
  parameter longint unsigned RATIO_Q = 64'd16452045;

  typedef enum logic [1:0] {
    CURVE_LOG1 = 2'b00,
    CURVE_LOG2 = 2'b01,
    CURVE_LIN  = 2'b10
  } curve_e;

  // Full scale attenuated n times by one 0.17 dB step, rounded to an integer.
  function automatic int unsigned atten_level(input int unsigned n, input int unsigned full);
    logic [63:0] acc;
    acc = 64'(full) << RATIO_FRAC;
    for (int unsigned i = 0; i < n; i++) begin
      acc = (acc * RATIO_Q + (64'd1 << (RATIO_FRAC - 1))) >> RATIO_FRAC;
    end
    acc = (acc + (64'd1 << (RATIO_FRAC - 1))) >> RATIO_FRAC;
    return acc[31:0];
  endfunction

endpackage

// File: rtl/logpwm_rst_sync.sv
module logpwm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/logpwm_curve.sv
module logpwm_curve
  import logpwm_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              lin_mode_i,
  input  logic              x2_scale_i,
  output logic [DUTY_W-1:0] duty_o
);

  localparam int CODE_MAX = (2 ** CODE_W) - 1;
  localparam int STEP_MAX = 2 * CODE_MAX;
  localparam int IDX_W    = $clog2(STEP_MAX + 1);
  localparam int ROM_N    = 2 ** IDX_W;
  localparam int FULL     = (2 ** DUTY_W) - 1;
  localparam int LIN_SH   = DUTY_W - CODE_W;

  logic [DUTY_W-1:0] lvl_rom [ROM_N];

  // One entry per attenuation step count, computed at elaboration.
  for (genvar g = 0; g < ROM_N; g++) begin : g_lvl
    localparam int unsigned LVL = atten_level(g, FULL);
    assign lvl_rom[g] = DUTY_W'(LVL);
  end

  curve_e            sel;
  logic [CODE_W-1:0] steps;
  logic [IDX_W-1:0]  idx;
  logic [DUTY_W-1:0] log_val;
  logic [DUTY_W-1:0] lin_val;

  always_comb begin
    if (lin_mode_i) begin
      sel = CURVE_LIN;
    end else if (x2_scale_i) begin
      sel = CURVE_LOG2;
    end else begin
      sel = CURVE_LOG1;
    end
  end

  always_comb begin
    steps = CODE_W'(CODE_MAX) - code_i;
    if (sel == CURVE_LOG2) begin
      idx = IDX_W'({steps, 1'b0});
    end else begin
      idx = IDX_W'(steps);
    end
    log_val = lvl_rom[idx];
    lin_val = DUTY_W'(code_i) << LIN_SH;
  end

  always_comb begin
    if (sel == CURVE_LIN) begin
      duty_o = lin_val;
    end else if (code_i == '0) begin
      duty_o = '0;
    end else begin
      duty_o = log_val;
    end
  end

endmodule

// File: rtl/logpwm_cnt.sv
module logpwm_cnt
  import logpwm_pkg::*;
#(
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic              wrap_o
);

  localparam logic [DUTY_W-1:0] CNT_MAX = '1;

  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] cnt_d;

  always_comb begin
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = run_i & tick_i & (cnt_q == CNT_MAX);

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));

  // R10
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/logpwm_duty.sv
module logpwm_duty
  import logpwm_pkg::*;
#(
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wrap_i,
  input  logic [DUTY_W-1:0] tgt_i,
  input  logic [DUTY_W-1:0] cnt_i,
  output logic              pwm_o
);

  localparam logic [DUTY_W-1:0] CNT_MAX = '1;

  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] duty_d;
  logic              run_q;
  logic              run_d;

  always_comb begin
    run_d = en_i;
    if (!en_i || wrap_i) begin
      duty_d = tgt_i;
    end else begin
      duty_d = duty_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      run_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      run_q  <= run_d;
    end
  end

  assign pwm_o = run_q & (cnt_i < duty_q);

  // R9
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_i) |=> $stable(duty_q));

  // R3
  last_tick_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_MAX) |-> !pwm_o);

endmodule

// File: rtl/logpwm_gen.sv
module logpwm_gen
  import logpwm_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int DUTY_W = DUTY_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              lin_mode_i,
  input  logic              x2_scale_i,
  output logic              pwm_o
);

  localparam int LIN_SH = DUTY_W - CODE_W;

  logic              rst_q_n;
  logic [DUTY_W-1:0] tgt_duty;
  logic [DUTY_W-1:0] cnt;
  logic              wrap;

  logpwm_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_q_n)
  );

  logpwm_curve #(
    .CODE_W (CODE_W),
    .DUTY_W (DUTY_W)
  ) u_curve (
    .code_i     (code_i),
    .lin_mode_i (lin_mode_i),
    .x2_scale_i (x2_scale_i),
    .duty_o     (tgt_duty)
  );

  logpwm_cnt #(
    .DUTY_W (DUTY_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_q_n),
    .run_i  (en_i),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  logpwm_duty #(
    .DUTY_W (DUTY_W)
  ) u_duty (
    .clk_i  (clk_i),
    .rst_ni (rst_q_n),
    .en_i   (en_i),
    .wrap_i (wrap),
    .tgt_i  (tgt_duty),
    .cnt_i  (cnt),
    .pwm_o  (pwm_o)
  );

  // R10
  off_after_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !en_i |=> !pwm_o);

  // R6
  zero_code_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (code_i == '0) |-> (tgt_duty == '0));

  // R7
  lin_map_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    lin_mode_i |-> (tgt_duty == (DUTY_W'(code_i) << LIN_SH)));

endmodule

// File: tb/sim_logpwm_gen.sv
module sim_logpwm_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       tick;
  logic [7:0] code;
  logic       lin;
  logic       x2;
  logic       pwm;

  int total = 0;
  int bad   = 0;

  bit m_run;
  int m_cnt;
  int m_lo;
  int m_hi;
  int mis;
  int highs;

  always #4 clk = ~clk;

  logpwm_gen u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .tick_i     (tick),
    .code_i     (code),
    .lin_mode_i (lin),
    .x2_scale_i (x2),
    .pwm_o      (pwm)
  );

  function automatic void exp_range(input int c, input bit l, input bit s2,
                                    output int lo, output int hi);
    if (l) begin
      lo = c * 16;
      hi = lo;
    end else if (c == 0) begin
      lo = 0;
      hi = 0;
    end else begin
      real e;
      real v;
      int  r;
      e  = (real'(c) - 255.0) * 0.17 * (s2 ? 2.0 : 1.0) / 20.0;
      v  = 4095.0 * (10.0 ** e);
      r  = $rtoi(v + 0.5);
      lo = (r > 0) ? r - 1 : 0;
      hi = (r < 4095) ? r + 1 : 4095;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // One clock: inputs are already set; model follows the edge; output read at negedge.
  task automatic cyc(input bit t);
    int lo;
    int hi;
    tick = t;
    @(posedge clk);
    exp_range(int'(code), lin, x2, lo, hi);
    m_run = en;
    if (!en) begin
      m_cnt = 0;
      m_lo  = lo;
      m_hi  = hi;
    end else if (t) begin
      if (m_cnt == 4095) begin
        m_cnt = 0;
        m_lo  = lo;
        m_hi  = hi;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    @(negedge clk);
    if (!m_run) begin
      if (pwm) mis++;
    end else if (m_cnt < m_lo) begin
      if (!pwm) mis++;
    end else if (m_cnt >= m_hi) begin
      if (pwm) mis++;
    end
    if (pwm) highs++;
  endtask

  task automatic run(input int n, input int per);
    for (int i = 0; i < n; i++) cyc((i % per) == 0);
  endtask

  task automatic measure(input int c, input bit l, input bit s2, input string req);
    int lo;
    int hi;
    en = 1'b0; code = 8'(c); lin = l; x2 = s2;
    cyc(1'b1);
    en = 1'b1; mis = 0; highs = 0;
    run(4096, 1);
    exp_range(c, l, s2, lo, hi);
    chk((highs >= lo) && (highs <= hi), req, $sformatf("high ticks code=%0d lin=%0d x2=%0d", c, l, s2), highs, lo);
    chk(mis == 0, req, "per-cycle mismatches", mis, 0);
    en = 1'b0;
    cyc(1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; tick = 1'b1; code = 8'd255; lin = 1'b1; x2 = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(pwm == 1'b0, "R1", "output during reset", int'(pwm), 0);
    end
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(pwm == 1'b0, "R1", "output after reset release", int'(pwm), 0);
    m_run = 1'b0; m_cnt = 0; m_lo = 0; m_hi = 0;
    mis = 0;
    run(4, 1);
    chk(mis == 0, "R1", "disabled after reset", mis, 0);
  endtask

  task automatic t_log1x();
    measure(255, 1'b0, 1'b0, "R3");
    measure(254, 1'b0, 1'b0, "R4");
    measure(219, 1'b0, 1'b0, "R4");
    measure(128, 1'b0, 1'b0, "R4");
    measure(40,  1'b0, 1'b0, "R4");
    measure(1,   1'b0, 1'b0, "R4");
  endtask

  task automatic t_log2x();
    measure(255, 1'b0, 1'b1, "R5");
    measure(250, 1'b0, 1'b1, "R5");
    measure(200, 1'b0, 1'b1, "R5");
    measure(128, 1'b0, 1'b1, "R5");
    measure(1,   1'b0, 1'b1, "R5");
  endtask

  task automatic t_zero();
    measure(0, 1'b0, 1'b0, "R6");
    measure(0, 1'b0, 1'b1, "R6");
  endtask

  task automatic t_linear();
    measure(128, 1'b1, 1'b0, "R7");
    measure(255, 1'b1, 1'b1, "R7");
    measure(1,   1'b1, 1'b1, "R7");
  endtask

  task automatic t_modes();
    measure(200, 1'b0, 1'b0, "R8");
    measure(200, 1'b0, 1'b1, "R8");
    measure(200, 1'b1, 1'b1, "R8");
  endtask

  task automatic t_tick_gap();
    en = 1'b0; code = 8'd100; lin = 1'b1; x2 = 1'b0;
    cyc(1'b1);
    en = 1'b1; mis = 0; highs = 0;
    run(3 * 4096, 3);
    chk(highs == 3 * 1600, "R2", "high clocks with tick every third clock", highs, 4800);
    chk(mis == 0, "R2", "per-cycle mismatches with sparse tick", mis, 0);
    en = 1'b0;
    cyc(1'b1);
  endtask

  task automatic t_wrap_latch();
    en = 1'b0; code = 8'd255; lin = 1'b1; x2 = 1'b0;
    cyc(1'b1);
    en = 1'b1; mis = 0;
    run(2000, 1);
    code = 8'd1;
    run(1000, 1);
    chk(pwm == 1'b1, "R9", "old duty kept mid-period", int'(pwm), 1);
    run(1096, 1);
    run(50, 1);
    chk(pwm == 1'b0, "R9", "new duty after wrap", int'(pwm), 0);
    chk(mis == 0, "R9", "per-cycle mismatches around wrap", mis, 0);
    en = 1'b0;
    cyc(1'b1);
  endtask

  task automatic t_disable();
    en = 1'b0; code = 8'd255; lin = 1'b1; x2 = 1'b0;
    cyc(1'b1);
    en = 1'b1;
    run(100, 1);
    chk(pwm == 1'b1, "R10", "running before disable", int'(pwm), 1);
    en = 1'b0;
    cyc(1'b1);
    chk(pwm == 1'b0, "R10", "output low after disable", int'(pwm), 0);
    en = 1'b1; highs = 0; mis = 0;
    run(4096, 1);
    chk(highs == 4080, "R10", "full period after restart", highs, 4080);
    chk(mis == 0, "R10", "per-cycle mismatches after restart", mis, 0);
    en = 1'b0;
    cyc(1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog: cycles=%0d expected<%0d", 190000, 190000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_log1x();
    t_log2x();
    t_zero();
    t_linear();
    t_modes();
    t_tick_gap();
    t_wrap_latch();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule